// File: doc/BRIEF.md
# CAN Host Interrupt and Status Unit

This block is the host-side register and interrupt logic of a CAN controller. The host reaches four byte-wide registers through a small synchronous bus: control, command, status and interrupt. The protocol core reports its events and levels to the block. These are transmit buffer free, transmission done, message waiting, message lost, error level, bus-off level, bus activity and a bit-quantum tick. From these the block keeps the status bits and the interrupt flags, and it drives an active-low interrupt line.

Host commands reach the core as one-cycle pulses: transmit request, abort and buffer release. A go-to-sleep command is answered with either a sleep-request pulse or a wake-up interrupt. Interrupt flags clear when the host reads them. The receive flag is armed again after a buffer release if a further message is still waiting. The overrun flag and the transmit flag fire only on a rising edge of their status bit.

Register map (2-bit address): 0 control, 1 command, 2 status, 3 interrupt.

Top module: `canHostIrqTop`

## Requirements
- R1: Any read of the interrupt register (address 3) clears every flag that is not being set in that same cycle. While any flag is set, `irqN` is 0. It returns to 1 once all flags are clear. The interrupt register reads {3'b111, wake, overrun, error, transmit, receive}, with receive at bit 0.
- R2: When `msgAvail` rises and receive enable (control bit 1) is 1, the receive flag is set. A read clears it even if `msgAvail` stays 1.
- R3: A release command (command bit 2) records a re-arm. At the next `quantumTick` after it, the receive flag is set again if `msgAvail` is still 1 and receive enable is 1.
- R4: The transmit flag is set only on a 0-to-1 change of `txBufFree`, and only while transmit enable (control bit 2) is 1.
- R5: `overrunEvt` sets the overrun status bit (status bit 1). The overrun flag is set only when that bit goes from 0 to 1 and overrun enable (control bit 4) is 1. The clear-overrun command (command bit 3) clears the status bit, and it acts together with a release command given in the same write.
- R6: The error flag is set on any change of `errStatus` or `busStatus` while error enable (control bit 3) is 1.
- R7: A read of the command register returns 8'hFF. Control reads {0, spare, 1, ovrIe, errIe, txIe, rxIe, resetMode}. The spare bit 6 holds the value written to it and has no other effect.
- R8: A transmit request (command bit 0) sets `txPending` and clears transmission-complete (status bit 3). `txDone` sets transmission-complete and clears `txPending`. Writing 0 to the command register leaves `txPending` unchanged; only abort (command bit 1) or `txDone` clears it.
- R9: Go-to-sleep (command bit 4) has no effect while `resetMode` is 1. Otherwise it sets the wake flag (bit 4) if `busActive` is 1 or any flag is set. If neither holds, it pulses `sleepReq`.
- R10: Each command pulse (`cmdTxReq`, `cmdAbort`, `cmdRelease`, `sleepReq`) is high for one cycle, in the cycle after the write edge. Commands written on consecutive cycles each produce their own pulse.
- R11: After reset, control reads 8'h21 (reset mode on, all enables off), every flag is 0, `irqN` is 1 and transmission-complete is 1. The status register reads {busStatus, errStatus, 0, busActive, txComplete, txBufFree, overrun, msgAvail}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addr | input | 2 | Register address |
| wrData | input | 8 | Write data |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe (clears flags on the interrupt register) |
| rdData | output | 8 | Read data for the current address, combinational |
| txBufFree | input | 1 | Transmit buffer is free (level) |
| txDone | input | 1 | Transmission finished successfully (pulse) |
| msgAvail | input | 1 | A received message is waiting (level) |
| overrunEvt | input | 1 | A message was lost for lack of space (pulse) |
| errStatus | input | 1 | Error counter at or above the warning limit (level) |
| busStatus | input | 1 | Bus-off (level) |
| busActive | input | 1 | Bus activity in progress (level) |
| quantumTick | input | 1 | One-cycle tick per bit quantum |
| irqN | output | 1 | Interrupt line, active low |
| resetMode | output | 1 | Reset-mode bit from the control register |
| txPending | output | 1 | A transmit request is outstanding |
| cmdTxReq | output | 1 | Transmit request pulse |
| cmdAbort | output | 1 | Abort pulse |
| cmdRelease | output | 1 | Receive buffer release pulse |
| sleepReq | output | 1 | Sleep entry accepted pulse |

## Verification
Flags, status bits, `txPending` and `irqN` change on the clock edge that samples the causing input or write, so they are visible one half-cycle later. Command pulses come from one register stage after the write edge. They are high in the cycle that starts at that edge and low one cycle later. Read data is combinational, so each read is checked in the cycle its address is driven, before the edge that clears the flags. The driver applies every stimulus at a falling edge and queues its expected result to be compared at the next falling edge, which is the first point where the result is due.

// File: rtl/hostIrqPkg.sv
package hostIrqPkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;
  localparam int FLAG_W = 5;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CMD  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_IRQ  = 2'd3;

  localparam int CMD_TX    = 0;
  localparam int CMD_ABORT = 1;
  localparam int CMD_REL   = 2;
  localparam int CMD_CLROV = 3;
  localparam int CMD_SLEEP = 4;

  localparam int IRQ_RX   = 0;
  localparam int IRQ_TX   = 1;
  localparam int IRQ_ERR  = 2;
  localparam int IRQ_OVR  = 3;
  localparam int IRQ_WAKE = 4;

  typedef struct packed {
    logic ctrlWr;
    logic wrRm;
    logic wrRxIe;
    logic wrTxIe;
    logic wrErrIe;
    logic wrOvrIe;
    logic wrSpare;
    logic txReq;
    logic abort;
    logic relBuf;
    logic clrOvr;
    logic sleep;
    logic irqRd;
  } strobeT;
endpackage

// File: rtl/hostIrqCtrl.sv
module hostIrqCtrl
  import hostIrqPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrEn,
  input  logic              rdEn,
  output strobeT            stb,
  output logic              cmdTxReq,
  output logic              cmdAbort,
  output logic              cmdRelease
);
  logic isCmd;
  logic isCtrl;
  logic unusedBits;

  assign unusedBits = ^{wrData[7], wrData[5]};

  always_comb begin
    isCmd  = wrEn && (addr == ADDR_CMD);
    isCtrl = wrEn && (addr == ADDR_CTRL);
    stb         = '0;
    stb.ctrlWr  = isCtrl;
    stb.wrRm    = wrData[0];
    stb.wrRxIe  = wrData[1];
    stb.wrTxIe  = wrData[2];
    stb.wrErrIe = wrData[3];
    stb.wrOvrIe = wrData[4];
    stb.wrSpare = wrData[6];
    stb.txReq   = isCmd && wrData[CMD_TX];
    stb.abort   = isCmd && wrData[CMD_ABORT];
    stb.relBuf  = isCmd && wrData[CMD_REL];
    stb.clrOvr  = isCmd && wrData[CMD_CLROV];
    stb.sleep   = isCmd && wrData[CMD_SLEEP];
    stb.irqRd   = rdEn && (addr == ADDR_IRQ);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdTxReq   <= 1'b0;
      cmdAbort   <= 1'b0;
      cmdRelease <= 1'b0;
    end else begin
      cmdTxReq   <= stb.txReq;
      cmdAbort   <= stb.abort;
      cmdRelease <= stb.relBuf;
    end
  end

  assert_tx_pulse_src_R10: assert property (@(posedge clk) disable iff (!rstN)
    cmdTxReq |-> $past(wrEn && (addr == ADDR_CMD) && wrData[CMD_TX]));
  assert_rel_pulse_src_R10: assert property (@(posedge clk) disable iff (!rstN)
    cmdRelease |-> $past(wrEn && (addr == ADDR_CMD) && wrData[CMD_REL]));
endmodule

// File: rtl/hostIrqData.sv
module hostIrqData
  import hostIrqPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic              txBufFree,
  input  logic              txDone,
  input  logic              msgAvail,
  input  logic              overrunEvt,
  input  logic              errStatus,
  input  logic              busStatus,
  input  logic              busActive,
  input  logic              quantumTick,
  output logic [DATA_W-1:0] rdData,
  output logic              irqN,
  output logic              resetMode,
  output logic              txPending,
  output logic              sleepReq
);
  logic rxIe, txIe, errIe, ovrIe, ctrlSpare;
  logic ovrStatus, txComplete, rearmPend;
  logic prevTxFree, prevMsg, prevErr, prevBus;
  logic [FLAG_W-1:0] irqFlags, setVec, flagsNext;
  logic sleepCmd, anyFlag;

  always_comb begin
    anyFlag  = |irqFlags;
    sleepCmd = stb.sleep && !resetMode;
    setVec = '0;
    setVec[IRQ_RX]   = rxIe && msgAvail && (!prevMsg || (rearmPend && quantumTick));
    setVec[IRQ_TX]   = txIe && txBufFree && !prevTxFree;
    setVec[IRQ_ERR]  = errIe && ((errStatus != prevErr) || (busStatus != prevBus));
    setVec[IRQ_OVR]  = ovrIe && overrunEvt && !ovrStatus;
    setVec[IRQ_WAKE] = sleepCmd && (busActive || anyFlag);
    flagsNext = (stb.irqRd ? '0 : irqFlags) | setVec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resetMode  <= 1'b1;
      rxIe       <= 1'b0;
      txIe       <= 1'b0;
      errIe      <= 1'b0;
      ovrIe      <= 1'b0;
      ctrlSpare  <= 1'b0;
      ovrStatus  <= 1'b0;
      txComplete <= 1'b1;
      txPending  <= 1'b0;
      rearmPend  <= 1'b0;
      prevTxFree <= 1'b1;
      prevMsg    <= 1'b0;
      prevErr    <= 1'b0;
      prevBus    <= 1'b0;
      irqFlags   <= '0;
      irqN       <= 1'b1;
      sleepReq   <= 1'b0;
    end else begin
      if (stb.ctrlWr) begin
        resetMode <= stb.wrRm;
        rxIe      <= stb.wrRxIe;
        txIe      <= stb.wrTxIe;
        errIe     <= stb.wrErrIe;
        ovrIe     <= stb.wrOvrIe;
        ctrlSpare <= stb.wrSpare;
      end
      if (overrunEvt)      ovrStatus <= 1'b1;
      else if (stb.clrOvr) ovrStatus <= 1'b0;
      if (stb.txReq)       txComplete <= 1'b0;
      else if (txDone)     txComplete <= 1'b1;
      if (stb.txReq)                 txPending <= 1'b1;
      else if (stb.abort || txDone)  txPending <= 1'b0;
      rearmPend  <= stb.relBuf || (rearmPend && !quantumTick);
      prevTxFree <= txBufFree;
      prevMsg    <= msgAvail;
      prevErr    <= errStatus;
      prevBus    <= busStatus;
      irqFlags   <= flagsNext;
      irqN       <= ~|flagsNext;
      sleepReq   <= sleepCmd && !busActive && !anyFlag;
    end
  end

  always_comb begin
    unique case (addr)
      ADDR_CTRL: rdData = {1'b0, ctrlSpare, 1'b1, ovrIe, errIe, txIe, rxIe, resetMode};
      ADDR_CMD:  rdData = 8'hFF;
      ADDR_STAT: rdData = {busStatus, errStatus, 1'b0, busActive,
                           txComplete, txBufFree, ovrStatus, msgAvail};
      default:   rdData = {3'b111, irqFlags};
    endcase
  end

  assert_irq_pin_R1: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlags != '0) |-> !irqN);
  assert_read_clear_R1: assert property (@(posedge clk) disable iff (!rstN)
    (stb.irqRd && (setVec == '0)) |=> (irqFlags == '0));
  assert_rx_needs_msg_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlags[IRQ_RX]) |-> $past(msgAvail && rxIe));
  assert_tx_needs_en_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlags[IRQ_TX]) |-> $past(txIe && txBufFree));
  assert_ovr_once_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ovrStatus && overrunEvt && !stb.irqRd && !irqFlags[IRQ_OVR]) |=> !irqFlags[IRQ_OVR]);
  assert_txreq_R8: assert property (@(posedge clk) disable iff (!rstN)
    stb.txReq |=> (txPending && !txComplete));
  assert_sleep_blocked_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.sleep && resetMode) |=> !sleepReq);
endmodule

// File: rtl/canHostIrqTop.sv
module canHostIrqTop
  import hostIrqPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrEn,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  input  logic              txBufFree,
  input  logic              txDone,
  input  logic              msgAvail,
  input  logic              overrunEvt,
  input  logic              errStatus,
  input  logic              busStatus,
  input  logic              busActive,
  input  logic              quantumTick,
  output logic              irqN,
  output logic              resetMode,
  output logic              txPending,
  output logic              cmdTxReq,
  output logic              cmdAbort,
  output logic              cmdRelease,
  output logic              sleepReq
);
  strobeT stb;

  hostIrqCtrl uCtrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .wrEn(wrEn),
    .rdEn(rdEn), .stb(stb), .cmdTxReq(cmdTxReq), .cmdAbort(cmdAbort),
    .cmdRelease(cmdRelease)
  );

  hostIrqData uData (
    .clk(clk), .rstN(rstN), .stb(stb), .addr(addr), .txBufFree(txBufFree),
    .txDone(txDone), .msgAvail(msgAvail), .overrunEvt(overrunEvt),
    .errStatus(errStatus), .busStatus(busStatus), .busActive(busActive),
    .quantumTick(quantumTick), .rdData(rdData), .irqN(irqN),
    .resetMode(resetMode), .txPending(txPending), .sleepReq(sleepReq)
  );
endmodule

// File: tb/sim_canHostIrqTop.sv
`timescale 1ns/100ps
module sim_canHostIrqTop;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wrData = '0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] rdData;
  logic txBufFree = 1'b1, txDone = 1'b0, msgAvail = 1'b0, overrunEvt = 1'b0;
  logic errStatus = 1'b0, busStatus = 1'b0, busActive = 1'b0, quantumTick = 1'b0;
  logic irqN, resetMode, txPending, cmdTxReq, cmdAbort, cmdRelease, sleepReq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  typedef struct {
    string tag;
    int    sel;
    logic [7:0] exp;
  } itemT;
  itemT q[$];
  event chk;

  always #2.5 clk = ~clk;

  canHostIrqTop u0 (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .wrEn(wrEn),
    .rdEn(rdEn), .rdData(rdData), .txBufFree(txBufFree), .txDone(txDone),
    .msgAvail(msgAvail), .overrunEvt(overrunEvt), .errStatus(errStatus),
    .busStatus(busStatus), .busActive(busActive), .quantumTick(quantumTick),
    .irqN(irqN), .resetMode(resetMode), .txPending(txPending),
    .cmdTxReq(cmdTxReq), .cmdAbort(cmdAbort), .cmdRelease(cmdRelease),
    .sleepReq(sleepReq)
  );

  // monitor: pops expected items and compares with the observed signal
  initial begin
    forever begin
      @(chk);
      while (q.size() != 0) begin
        itemT it;
        logic [7:0] got;
        it = q.pop_front();
        case (it.sel)
          0: got = rdData;
          1: got = {7'b0, irqN};
          2: got = {4'b0, sleepReq, cmdRelease, cmdAbort, cmdTxReq};
          default: got = {7'b0, txPending};
        endcase
        checks++;
        if (got !== it.exp) begin
          errors++;
          $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
        end
      end
    end
  end

  task automatic expect_(input string tag, input int sel, input logic [7:0] exp);
    itemT it;
    it.tag = tag; it.sel = sel; it.exp = exp;
    q.push_back(it);
    -> chk;
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rdReg(input string tag, input logic [1:0] a, input logic [7:0] exp);
    @(negedge clk); addr = a; rdEn = (a == 2'd3);
    #1 expect_(tag, 0, exp);
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic pulseIn(input int which);
    @(negedge clk);
    case (which)
      0: txDone = 1'b1;
      1: overrunEvt = 1'b1;
      default: quantumTick = 1'b1;
    endcase
    @(negedge clk);
    txDone = 1'b0; overrunEvt = 1'b0; quantumTick = 1'b0;
  endtask

  task automatic setLvl(input int which, input logic v);
    @(negedge clk);
    case (which)
      0: txBufFree = v;
      1: msgAvail = v;
      2: errStatus = v;
      3: busStatus = v;
      default: busActive = v;
    endcase
    @(negedge clk);
  endtask

  initial begin
    #(100000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R11 reset state
    #1 expect_("R11 irqN after reset", 1, 8'h01);
    rdReg("R11 control after reset", 2'd0, 8'h21);
    rdReg("R11 status after reset", 2'd2, 8'h0C);
    rdReg("R11 flags after reset", 2'd3, 8'hE0);
    // R7 command reads FF, spare bit stored, bit5 reads 1
    rdReg("R7 command read", 2'd1, 8'hFF);
    wrReg(2'd0, 8'h5E);
    rdReg("R7 control readback", 2'd0, 8'h7E);
    // R2 receive flag and read-clear
    setLvl(1, 1'b1);
    expect_("R1 irqN low with receive flag", 1, 8'h00);
    rdReg("R2 receive flag set", 2'd3, 8'hE1);
    expect_("R1 irqN high after read", 1, 8'h01);
    rdReg("R2 cleared with message still waiting", 2'd3, 8'hE0);
    // R3 release re-arms at the next quantum tick
    wrReg(2'd1, 8'h04);
    expect_("R10 release pulse", 2, 8'h04);
    rdReg("R3 no re-fire before tick", 2'd3, 8'hE0);
    pulseIn(2);
    rdReg("R3 re-fire after tick", 2'd3, 8'hE1);
    // R4 transmit flag on rising edge only
    setLvl(0, 1'b0);
    rdReg("R4 no flag on falling edge", 2'd3, 8'hE0);
    setLvl(0, 1'b1);
    rdReg("R4 flag on rising edge", 2'd3, 8'hE2);
    wrReg(2'd0, 8'h5A);
    setLvl(0, 1'b0);
    setLvl(0, 1'b1);
    rdReg("R4 no flag when disabled", 2'd3, 8'hE0);
    wrReg(2'd0, 8'h5E);
    // R5 overrun
    pulseIn(1);
    rdReg("R5 overrun flag", 2'd3, 8'hE8);
    rdReg("R5 overrun status", 2'd2, 8'h0F);
    pulseIn(1);
    rdReg("R5 no second overrun flag", 2'd3, 8'hE0);
    wrReg(2'd1, 8'h0C);
    expect_("R5 release pulse with clear", 2, 8'h04);
    rdReg("R5 overrun status cleared", 2'd2, 8'h0D);
    pulseIn(2);
    rdReg("R5 release honoured with clear", 2'd3, 8'hE1);
    pulseIn(1);
    rdReg("R5 overrun flag again after clear", 2'd3, 8'hE8);
    // R6 error flag on change
    setLvl(2, 1'b1);
    rdReg("R6 error level change", 2'd3, 8'hE4);
    setLvl(3, 1'b1);
    rdReg("R6 bus-off change", 2'd3, 8'hE4);
    wrReg(2'd0, 8'h56);
    setLvl(2, 1'b0);
    setLvl(3, 1'b0);
    rdReg("R6 no flag when disabled", 2'd3, 8'hE0);
    wrReg(2'd0, 8'h5E);
    // R8 transmit request, complete and abort
    wrReg(2'd1, 8'h01);
    expect_("R10 transmit pulse", 2, 8'h01);
    expect_("R8 pending after request", 3, 8'h01);
    rdReg("R8 complete cleared", 2'd2, 8'h07);
    wrReg(2'd1, 8'h00);
    expect_("R8 write zero keeps pending", 3, 8'h01);
    wrReg(2'd1, 8'h02);
    expect_("R10 abort pulse", 2, 8'h02);
    expect_("R8 abort clears pending", 3, 8'h00);
    wrReg(2'd1, 8'h01);
    pulseIn(0);
    expect_("R8 done clears pending", 3, 8'h00);
    rdReg("R8 complete set by done", 2'd2, 8'h0F);
    // R10 back-to-back commands
    @(negedge clk); addr = 2'd1; wrData = 8'h01; wrEn = 1'b1;
    @(negedge clk);
    expect_("R10 first of back-to-back", 2, 8'h01);
    wrData = 8'h02;
    @(negedge clk);
    expect_("R10 second of back-to-back", 2, 8'h02);
    wrEn = 1'b0;
    expect_("R10 pending after both", 3, 8'h00);
    @(negedge clk);
    expect_("R10 pulses end", 2, 8'h00);
    // R9 sleep handling
    rdReg("R9 flags clear before sleep", 2'd3, 8'hE0);
    setLvl(4, 1'b1);
    wrReg(2'd1, 8'h10);
    expect_("R9 no sleep while bus active", 2, 8'h00);
    rdReg("R9 wake flag", 2'd3, 8'hF0);
    setLvl(4, 1'b0);
    wrReg(2'd1, 8'h10);
    expect_("R9 sleep request", 2, 8'h08);
    rdReg("R9 no wake when idle", 2'd3, 8'hE0);
    wrReg(2'd0, 8'h5F);
    wrReg(2'd1, 8'h10);
    expect_("R9 ignored in reset mode", 2, 8'h00);
    rdReg("R9 no wake in reset mode", 2'd3, 8'hE0);
    // R1 several flags cleared by one read
    setLvl(0, 1'b0);
    setLvl(0, 1'b1);
    setLvl(3, 1'b1);
    expect_("R1 irqN low with two flags", 1, 8'h00);
    rdReg("R1 two flags read", 2'd3, 8'hE6);
    expect_("R1 irqN released", 1, 8'h01);
    rdReg("R1 all clear", 2'd3, 8'hE0);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule